// File: doc/BRIEF.md
# UART Channel Mode Router

This block sits between the line side of a UART (the receiver's character strobe), the CPU data register and the two character FIFOs. A 2-bit channel-mode selector decides where each character goes. In normal operation received characters go to the receive FIFO and CPU writes go to the transmit FIFO. Echo mode sends received characters to both FIFOs. Local loopback turns CPU writes back into the receive FIFO. Remote loopback sends the line straight out through the transmit FIFO.

The router produces registered one-cycle push strobes, with data, for each FIFO. Pushes to a FIFO that is full or switched off are suppressed. An overrun cause pulse goes to the interrupt logic. The router also gives the line side a combinational count of how many characters it can take now. The FIFO storage, the baud generator and the serial framing live elsewhere.

Top module: `uart_chan_router`

## Requirements
- R1: The mode selector (bits 9:8 of the mode register, brought in as `mode_sel`) routes a line character as follows. Value 0 (normal) sends it to RX. Value 1 (echo) sends it to RX and TX. Value 2 (local loopback) sends it nowhere. Value 3 (remote loopback) sends it to TX.
- R2: A CPU data write goes to TX in mode 0 and to RX in mode 2. It is discarded in modes 1 and 3.
- R3: `line_room` starts from DEPTH (16). It is reduced to the free RX space in modes 0 and 1, and to the free TX space in modes 1 and 3. In mode 2 it stays at DEPTH.
- R4: A push into RX happens only while `rx_on`=1 and `rx_off`=0 (control bits 2 and 3). A push into TX happens only while `tx_on`=1 and `tx_off`=0 (control bits 4 and 5). A suppressed push raises no cause.
- R5: A push aimed at an enabled FIFO whose level equals DEPTH is dropped. It sets bit 5 of `cause_set` for exactly one cycle.
- R6: When a line character and a CPU write arrive in the same cycle, the line character is routed in that cycle. The CPU write is routed one cycle later, using the mode in force then.
- R7: Push strobes and `cause_set` are registered. They appear in the cycle after the request and stay low for one cycle unless a new request arrives. All of them are zero in reset.
- R8: The data presented with a push equals the character that caused it: `line_data` for line characters and `cpu_data` for CPU writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_sel | input | 2 | Channel mode selector |
| rx_on | input | 1 | Receive direction enable |
| rx_off | input | 1 | Receive direction disable |
| tx_on | input | 1 | Transmit direction enable |
| tx_off | input | 1 | Transmit direction disable |
| line_valid | input | 1 | Received character strobe |
| line_data | input | DATA_W | Received character |
| cpu_wr | input | 1 | CPU write of the data register |
| cpu_data | input | DATA_W | CPU write data |
| rx_level | input | LVL_W | Receive FIFO occupancy |
| tx_level | input | LVL_W | Transmit FIFO occupancy |
| rxf_push | output | 1 | Receive FIFO write strobe |
| rxf_data | output | DATA_W | Receive FIFO write data |
| txf_push | output | 1 | Transmit FIFO write strobe |
| txf_data | output | DATA_W | Transmit FIFO write data |
| line_room | output | LVL_W | Characters the line side may deliver |
| cause_set | output | CAUSE_W | Interrupt cause pulses, overrun at bit 5 |

## Verification
The hardest case to reach is a collision between a line character and a CPU write. In every mode the two target different FIFOs or one of them is discarded, so only the extra cycle of latency shows the deferral. The bench drives both strobes on the same edge, in local loopback and in normal mode. It then checks that the CPU push is absent after the first edge and present, with the CPU data, after the second. Overrun is reached by presenting a level of exactly DEPTH at the targeted FIFO. The same full level is also presented on a disabled direction, to show that no cause is raised there.

// File: rtl/ucr_pkg.sv
package ucr_pkg;

    typedef enum logic [1:0] {
        CH_NORMAL = 2'd0,
        CH_ECHO   = 2'd1,
        CH_LLOOP  = 2'd2,
        CH_RLOOP  = 2'd3
    } ch_mode_e;

    // Which FIFO each character source reaches in the current mode
    typedef struct packed {
        logic line_to_rx;
        logic line_to_tx;
        logic cpu_to_rx;
        logic cpu_to_tx;
    } route_t;

    localparam int DIR_RX    = 0;
    localparam int DIR_TX    = 1;
    localparam int NUM_DIR   = 2;
    localparam int CAUSE_OVR = 5;

endpackage

// File: rtl/ucr_route_decode.sv
module ucr_route_decode
    import ucr_pkg::*;
(
    input  logic [1:0] mode_sel,
    output route_t     route
);
    always_comb begin
        route = '0;
        case (ch_mode_e'(mode_sel))
            CH_NORMAL: begin
                route.line_to_rx = 1'b1;
                route.cpu_to_tx  = 1'b1;
            end
            CH_ECHO: begin
                route.line_to_rx = 1'b1;
                route.line_to_tx = 1'b1;
            end
            CH_LLOOP: begin
                route.cpu_to_rx  = 1'b1;
            end
            CH_RLOOP: begin
                route.line_to_tx = 1'b1;
            end
            default: route = '0;
        endcase
    end
endmodule

// File: rtl/ucr_space_calc.sv
module ucr_space_calc #(
    parameter int DEPTH = 16,
    parameter int LVL_W = $clog2(DEPTH + 1)
) (
    input  logic             limit_rx,
    input  logic             limit_tx,
    input  logic [LVL_W-1:0] rx_level,
    input  logic [LVL_W-1:0] tx_level,
    output logic [LVL_W-1:0] room
);
    localparam logic [LVL_W-1:0] FULL = LVL_W'(DEPTH);

    logic [LVL_W-1:0] rx_free;
    logic [LVL_W-1:0] tx_free;

    always_comb begin
        rx_free = (rx_level >= FULL) ? '0 : FULL - rx_level;
        tx_free = (tx_level >= FULL) ? '0 : FULL - tx_level;
        room    = FULL;
        if (limit_rx && (rx_free < room)) room = rx_free;
        if (limit_tx && (tx_free < room)) room = tx_free;
    end
endmodule

// File: rtl/ucr_push_gate.sv
module ucr_push_gate #(
    parameter int DEPTH = 16,
    parameter int LVL_W = $clog2(DEPTH + 1)
) (
    input  logic             req,
    input  logic             dir_on,
    input  logic             dir_off,
    input  logic [LVL_W-1:0] level,
    output logic             push,
    output logic             overrun
);
    localparam logic [LVL_W-1:0] FULL = LVL_W'(DEPTH);

    logic live;
    logic full;

    always_comb begin
        live    = req && dir_on && !dir_off;
        full    = (level >= FULL);
        push    = live && !full;
        overrun = live && full;
    end
endmodule

// File: rtl/uart_chan_router.sv
module uart_chan_router
    import ucr_pkg::*;
#(
    parameter  int DATA_W  = 8,
    parameter  int DEPTH   = 16,
    parameter  int CAUSE_W = 13,
    localparam int LVL_W   = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        mode_sel,
    input  logic              rx_on,
    input  logic              rx_off,
    input  logic              tx_on,
    input  logic              tx_off,
    input  logic              line_valid,
    input  logic [DATA_W-1:0] line_data,
    input  logic              cpu_wr,
    input  logic [DATA_W-1:0] cpu_data,
    input  logic [LVL_W-1:0]  rx_level,
    input  logic [LVL_W-1:0]  tx_level,
    output logic              rxf_push,
    output logic [DATA_W-1:0] rxf_data,
    output logic              txf_push,
    output logic [DATA_W-1:0] txf_data,
    output logic [LVL_W-1:0]  line_room,
    output logic [CAUSE_W-1:0] cause_set
);

    typedef struct packed {
        logic               rx_push;
        logic [DATA_W-1:0]  rx_dat;
        logic               tx_push;
        logic [DATA_W-1:0]  tx_dat;
        logic               held_v;
        logic [DATA_W-1:0]  held_dat;
        logic [CAUSE_W-1:0] cause;
    } state_t;

    state_t st_q, st_d;
    route_t route;

    logic               cpu_req_v;
    logic [DATA_W-1:0]  cpu_req_dat;
    logic               cpu_go;
    logic [NUM_DIR-1:0] dir_req;
    logic [NUM_DIR-1:0] dir_on;
    logic [NUM_DIR-1:0] dir_off;
    logic [LVL_W-1:0]   dir_lvl [NUM_DIR];
    logic [NUM_DIR-1:0] dir_push;
    logic [NUM_DIR-1:0] dir_ovr;

    ucr_route_decode u_route (
        .mode_sel (mode_sel),
        .route    (route)
    );

    ucr_space_calc #(.DEPTH(DEPTH), .LVL_W(LVL_W)) u_space (
        .limit_rx (route.line_to_rx),
        .limit_tx (route.line_to_tx),
        .rx_level (rx_level),
        .tx_level (tx_level),
        .room     (line_room)
    );

    // Arbitration between the line and the CPU for the FIFO write ports
    always_comb begin
        cpu_req_v   = st_q.held_v || cpu_wr;
        cpu_req_dat = st_q.held_v ? st_q.held_dat : cpu_data;
        cpu_go      = cpu_req_v && !line_valid;

        dir_req[DIR_RX] = (line_valid && route.line_to_rx) || (cpu_go && route.cpu_to_rx);
        dir_req[DIR_TX] = (line_valid && route.line_to_tx) || (cpu_go && route.cpu_to_tx);

        dir_on[DIR_RX]  = rx_on;
        dir_off[DIR_RX] = rx_off;
        dir_on[DIR_TX]  = tx_on;
        dir_off[DIR_TX] = tx_off;
        dir_lvl[DIR_RX] = rx_level;
        dir_lvl[DIR_TX] = tx_level;
    end

    for (genvar d = 0; d < NUM_DIR; d++) begin : g_dir
        ucr_push_gate #(.DEPTH(DEPTH), .LVL_W(LVL_W)) u_gate (
            .req     (dir_req[d]),
            .dir_on  (dir_on[d]),
            .dir_off (dir_off[d]),
            .level   (dir_lvl[d]),
            .push    (dir_push[d]),
            .overrun (dir_ovr[d])
        );
    end

    always_comb begin
        st_d         = st_q;
        st_d.rx_push = dir_push[DIR_RX];
        st_d.tx_push = dir_push[DIR_TX];
        if (dir_push[DIR_RX]) st_d.rx_dat = line_valid ? line_data : cpu_req_dat;
        if (dir_push[DIR_TX]) st_d.tx_dat = line_valid ? line_data : cpu_req_dat;

        if (line_valid && cpu_req_v) begin
            st_d.held_v   = 1'b1;
            st_d.held_dat = cpu_req_dat;
        end else if (st_q.held_v && cpu_wr) begin
            st_d.held_v   = 1'b1;
            st_d.held_dat = cpu_data;
        end else begin
            st_d.held_v   = 1'b0;
        end

        st_d.cause            = '0;
        st_d.cause[CAUSE_OVR] = |dir_ovr;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rxf_push  = st_q.rx_push;
    assign rxf_data  = st_q.rx_dat;
    assign txf_push  = st_q.tx_push;
    assign txf_data  = st_q.tx_dat;
    assign cause_set = st_q.cause;

endmodule

// File: rtl/uart_chan_router_chk.sv
module uart_chan_router_chk #(
    parameter  int DATA_W  = 8,
    parameter  int DEPTH   = 16,
    parameter  int CAUSE_W = 13,
    localparam int LVL_W   = $clog2(DEPTH + 1)
) (
    input logic               clk,
    input logic               rst_n,
    input logic [1:0]         mode_sel,
    input logic               rx_on,
    input logic               rx_off,
    input logic               tx_on,
    input logic               tx_off,
    input logic [LVL_W-1:0]   rx_level,
    input logic [LVL_W-1:0]   tx_level,
    input logic               rxf_push,
    input logic               txf_push,
    input logic [LVL_W-1:0]   line_room,
    input logic [CAUSE_W-1:0] cause_set
);
    localparam logic [LVL_W-1:0] FULL = LVL_W'(DEPTH);

    AST_RX_NOT_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        rxf_push && $past(rst_n) |-> $past(rx_level) < FULL); // R5
    AST_TX_NOT_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        txf_push && $past(rst_n) |-> $past(tx_level) < FULL); // R5
    AST_OVR_NEEDS_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        cause_set[5] && $past(rst_n) |-> ($past(rx_level) == FULL || $past(tx_level) == FULL)); // R5
    AST_CAUSE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(cause_set)); // R5
    AST_RX_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        rxf_push && $past(rst_n) |-> $past(rx_on && !rx_off)); // R4
    AST_TX_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        txf_push && $past(rst_n) |-> $past(tx_on && !tx_off)); // R4
    AST_NO_RX_REMOTE: assert property (@(posedge clk) disable iff (!rst_n)
        rxf_push && $past(rst_n) |-> $past(mode_sel) != 2'd3); // R1
    AST_ROOM_LLOOP: assert property (@(posedge clk) disable iff (!rst_n)
        mode_sel == 2'd2 |-> line_room == FULL); // R3
    AST_ROOM_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        line_room <= FULL); // R3
endmodule

bind uart_chan_router uart_chan_router_chk #(
    .DATA_W(DATA_W), .DEPTH(DEPTH), .CAUSE_W(CAUSE_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .mode_sel(mode_sel),
    .rx_on(rx_on), .rx_off(rx_off), .tx_on(tx_on), .tx_off(tx_off),
    .rx_level(rx_level), .tx_level(tx_level),
    .rxf_push(rxf_push), .txf_push(txf_push),
    .line_room(line_room), .cause_set(cause_set)
);

// File: tb/uart_chan_router_test.sv
module uart_chan_router_test;
    localparam int CLK_PERIOD = 10;
    localparam int DATA_W  = 8;
    localparam int DEPTH   = 16;
    localparam int CAUSE_W = 13;
    localparam int LVL_W   = $clog2(DEPTH + 1);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [1:0] mode_sel = '0;
    logic rx_on = 1'b1, rx_off = 1'b0, tx_on = 1'b1, tx_off = 1'b0;
    logic line_valid = 1'b0;
    logic [DATA_W-1:0] line_data = '0;
    logic cpu_wr = 1'b0;
    logic [DATA_W-1:0] cpu_data = '0;
    logic [LVL_W-1:0] rx_level = '0, tx_level = '0;
    logic rxf_push, txf_push;
    logic [DATA_W-1:0] rxf_data, txf_data;
    logic [LVL_W-1:0] line_room;
    logic [CAUSE_W-1:0] cause_set;

    int total = 0;
    int bad = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    uart_chan_router #(.DATA_W(DATA_W), .DEPTH(DEPTH), .CAUSE_W(CAUSE_W)) uut (
        .clk(clk), .rst_n(rst_n), .mode_sel(mode_sel),
        .rx_on(rx_on), .rx_off(rx_off), .tx_on(tx_on), .tx_off(tx_off),
        .line_valid(line_valid), .line_data(line_data),
        .cpu_wr(cpu_wr), .cpu_data(cpu_data),
        .rx_level(rx_level), .tx_level(tx_level),
        .rxf_push(rxf_push), .rxf_data(rxf_data),
        .txf_push(txf_push), .txf_data(txf_data),
        .line_room(line_room), .cause_set(cause_set)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic quiet();
        line_valid = 1'b0;
        cpu_wr     = 1'b0;
    endtask

    task automatic t_reset();
        check("R7 reset rx push", 32'(rxf_push), 0);
        check("R7 reset tx push", 32'(txf_push), 0);
        check("R7 reset cause",   32'(cause_set), 0);
        rst_n = 1'b1;
        tick();
        check("R3 room after reset", 32'(line_room), DEPTH);
        check("R7 idle rx push", 32'(rxf_push), 0);
    endtask

    task automatic t_line_routing();
        for (int m = 0; m < 4; m++) begin
            mode_sel   = 2'(m);
            line_valid = 1'b1;
            line_data  = 8'hA0 + 8'(m);
            tick();
            quiet();
            check("R1 line to rx", 32'(rxf_push), (m == 0 || m == 1) ? 1 : 0);
            check("R1 line to tx", 32'(txf_push), (m == 1 || m == 3) ? 1 : 0);
            if (m == 1) begin
                check("R8 echo rx data", 32'(rxf_data), 32'h00A1);
                check("R8 echo tx data", 32'(txf_data), 32'h00A1);
            end
            tick();
            check("R7 push is one cycle", 32'(rxf_push | txf_push), 0);
        end
    endtask

    task automatic t_cpu_routing();
        for (int m = 0; m < 4; m++) begin
            mode_sel = 2'(m);
            cpu_wr   = 1'b1;
            cpu_data = 8'h50 + 8'(m);
            tick();
            quiet();
            check("R2 cpu to rx", 32'(rxf_push), (m == 2) ? 1 : 0);
            check("R2 cpu to tx", 32'(txf_push), (m == 0) ? 1 : 0);
            if (m == 0) check("R8 cpu tx data", 32'(txf_data), 32'h50);
            if (m == 2) check("R8 cpu rx data", 32'(rxf_data), 32'h52);
            tick();
        end
    endtask

    task automatic t_room();
        rx_level = 5'd10;
        tx_level = 5'd3;
        for (int m = 0; m < 4; m++) begin
            mode_sel = 2'(m);
            #1;
            check("R3 room", 32'(line_room), (m == 0) ? 6 : (m == 1) ? 6 : (m == 2) ? 16 : 13);
        end
        rx_level = 5'd2;
        tx_level = 5'd12;
        mode_sel = 2'd1;
        #1;
        check("R3 echo room from tx", 32'(line_room), 4);
        rx_level = 5'd16;
        mode_sel = 2'd0;
        #1;
        check("R3 room zero when full", 32'(line_room), 0);
        rx_level = '0;
        tx_level = '0;
        @(negedge clk);
    endtask

    task automatic t_enable();
        mode_sel = 2'd0;
        rx_on = 1'b0;
        line_valid = 1'b1; line_data = 8'h11;
        tick(); quiet();
        check("R4 rx off by enable", 32'(rxf_push), 0);
        rx_on = 1'b1; rx_off = 1'b1;
        rx_level = 5'd16;
        line_valid = 1'b1;
        tick(); quiet();
        check("R4 rx off by disable", 32'(rxf_push), 0);
        check("R4 no cause when disabled", 32'(cause_set), 0);
        rx_off = 1'b0; rx_level = '0;
        tx_off = 1'b1;
        cpu_wr = 1'b1; cpu_data = 8'h22;
        tick(); quiet();
        check("R4 tx off by disable", 32'(txf_push), 0);
        tx_off = 1'b0;
        tick();
    endtask

    task automatic t_full();
        mode_sel = 2'd0;
        tx_level = 5'd16;
        cpu_wr = 1'b1; cpu_data = 8'h33;
        tick(); quiet();
        check("R5 tx full dropped", 32'(txf_push), 0);
        check("R5 overrun bit 5", 32'(cause_set), 32'h20);
        tick();
        check("R5 overrun pulse ends", 32'(cause_set), 0);
        tx_level = '0;
        rx_level = 5'd16;
        line_valid = 1'b1; line_data = 8'h44;
        tick(); quiet();
        check("R5 rx full dropped", 32'(rxf_push), 0);
        check("R5 rx overrun bit 5", 32'(cause_set), 32'h20);
        rx_level = 5'd15;
        line_valid = 1'b1; line_data = 8'h45;
        tick(); quiet();
        check("R5 last slot accepted", 32'(rxf_push), 1);
        check("R5 no cause on last slot", 32'(cause_set), 0);
        rx_level = '0;
        tick();
    endtask

    task automatic t_collide();
        mode_sel = 2'd2;
        line_valid = 1'b1; line_data = 8'h66;
        cpu_wr = 1'b1; cpu_data = 8'h77;
        tick(); quiet();
        check("R6 cpu deferred first edge", 32'(rxf_push), 0);
        tick();
        check("R6 cpu pushed second edge", 32'(rxf_push), 1);
        check("R6 deferred data", 32'(rxf_data), 32'h77);
        tick();
        mode_sel = 2'd0;
        line_valid = 1'b1; line_data = 8'h88;
        cpu_wr = 1'b1; cpu_data = 8'h99;
        tick(); quiet();
        check("R6 line first rx", 32'(rxf_push), 1);
        check("R6 line data", 32'(rxf_data), 32'h88);
        check("R6 tx waits", 32'(txf_push), 0);
        tick();
        check("R6 tx after one cycle", 32'(txf_push), 1);
        check("R6 tx data", 32'(txf_data), 32'h99);
        tick();
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        t_line_routing();
        t_cpu_routing();
        t_room();
        t_enable();
        t_full();
        t_collide();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog: actual=running expected=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule